// File: doc/BRIEF.md
# Wishbone Classic Register Access Bridge

This block sits between a Wishbone B4 classic slave port and a simple internal register-access port. A single read or single write on the bus is captured on strobe and becomes one request to the register target. The request carries address, write data, a per-byte write mask taken from the byte selects, and a read/write flag. The target answers with a one-cycle done pulse together with read data and two fault flags: the address decodes to no register, or the access direction is not allowed at that location. The bridge turns that answer into exactly one acknowledge or exactly one error pulse on the bus.

The cycle input exists only for port compatibility and has no effect. Each fault class can be turned into a bus error by its own parameter. When a class is not enabled, the faulted access completes with a normal acknowledge and returns zero as read data. The bridge holds stall high while a request is outstanding. Bus activity in that window is ignored.

Top module: `wb_reg_bridge`

## Requirements
- R1: In the idle state, a cycle with `bus_stb` high captures `bus_adr`, `bus_wdat`, `bus_we` and `bus_sel`, whatever the level of `bus_cyc`. From the next cycle `req_valid` is high and `req_addr`, `req_wdata`, `req_write` present the captured values until `rsp_done`.
- R2: If `rsp_done` is high while a request is outstanding, exactly one of `bus_ack` and `bus_err` is high in the following cycle, for that one cycle only. With a target that raises done L cycles after `req_valid` rises, the response appears L+2 cycles after strobe is first presented.
- R3: `bus_stall` is high from the cycle after capture up to and including the response cycle. It is low in idle.
- R4: While a request is outstanding or being answered, strobe and every change on the bus inputs are ignored. The access that completes is the one captured.
- R5: With `ERR_BAD_ADDR`=1, a done carrying `rsp_bad_addr` produces `bus_err` high with `bus_ack` low.
- R6: With `ERR_BAD_DIR`=1, a done carrying `rsp_bad_dir` produces `bus_err` high with `bus_ack` low.
- R7: For a fault class whose parameter is 0, the faulted access ends with `bus_ack` and no error. A read returns zero in that case.
- R8: `bus_ack` and `bus_err` are never high in the same cycle.
- R9: `bus_rdat` equals the target's read data only in the acknowledge cycle of a read with no fault flag. It is zero in every other cycle.
- R10: While `rst_n` is low, `bus_ack`, `bus_err`, `bus_stall` and `req_valid` are low and any outstanding request is dropped. A strobe presented at the first clock edge after release is captured.
- R11: Bit i of `bus_sel` appears as bit i of `req_wmask` and qualifies byte i (bits 8i+7..8i) of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle input, not used |
| bus_stb | input | 1 | Bus strobe, starts an access |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | ADDR_W | Bus address |
| bus_wdat | input | DATA_W | Bus write data |
| bus_sel | input | DATA_W/8 | Bus byte selects |
| bus_stall | output | 1 | Bridge cannot accept a strobe |
| bus_ack | output | 1 | Normal completion pulse |
| bus_err | output | 1 | Error completion pulse |
| bus_rdat | output | DATA_W | Read data, valid with ack on reads |
| req_valid | output | 1 | Request outstanding to the target |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Request write data |
| req_wmask | output | DATA_W/8 | Request per-byte write mask |
| rsp_done | input | 1 | Target completion pulse |
| rsp_rdata | input | DATA_W | Target read data |
| rsp_bad_addr | input | 1 | Target: address hits no register |
| rsp_bad_dir | input | 1 | Target: direction not allowed there |

## Verification
Two things can meet in one cycle. A fault flag can arrive on the same done as read data, and that must select between error and acknowledge while also zeroing the returned data. Bus inputs can also change in the cycle a request is being issued, which must not alter the request. The bench provokes the first with a target model that returns a nonzero junk word alongside every fault. It runs one bridge with both error options on and one with both off, and compares flags and data on both against an independent shadow of the register map. That map has eight read/write words at 0–7, a read-only constant at 8, a write-only word at 9 and nothing above. For the second, the bench flips address, data and direction right after capture, then reads both the intended and the mutated locations back.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } wbb_state_e;

endpackage

// File: rtl/wbb_classify.sv
module wbb_classify #(
    parameter int DATA_W       = 32,
    parameter bit ERR_BAD_ADDR = 1'b1,
    parameter bit ERR_BAD_DIR  = 1'b1
) (
    input  logic              is_read,
    input  logic              bad_addr,
    input  logic              bad_dir,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              raise_err,
    output logic [DATA_W-1:0] ret_rdata
);

    logic addr_err;
    logic dir_err;

    generate
        if (ERR_BAD_ADDR) begin : g_addr_on
            assign addr_err = bad_addr;
        end else begin : g_addr_off
            assign addr_err = 1'b0;
        end
        if (ERR_BAD_DIR) begin : g_dir_on
            assign dir_err = bad_dir;
        end else begin : g_dir_off
            assign dir_err = 1'b0;
        end
    endgenerate

    always_comb begin
        raise_err = addr_err | dir_err;
        // any fault, reported or not, yields zero data
        if (is_read && !bad_addr && !bad_dir) begin
            ret_rdata = tgt_rdata;
        end else begin
            ret_rdata = '0;
        end
    end

endmodule

// File: rtl/wb_reg_bridge.sv
module wb_reg_bridge
    import wbb_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter bit ERR_BAD_ADDR = 1'b1,
    parameter bit ERR_BAD_DIR  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cyc,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_adr,
    input  logic [DATA_W-1:0]   bus_wdat,
    input  logic [DATA_W/8-1:0] bus_sel,
    output logic                bus_stall,
    output logic                bus_ack,
    output logic                bus_err,
    output logic [DATA_W-1:0]   bus_rdat,
    output logic                req_valid,
    output logic                req_write,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W/8-1:0] req_wmask,
    input  logic                rsp_done,
    input  logic [DATA_W-1:0]   rsp_rdata,
    input  logic                rsp_bad_addr,
    input  logic                rsp_bad_dir
);

    localparam int SEL_W = DATA_W / 8;

    typedef struct packed {
        wbb_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [SEL_W-1:0]  wmask;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdat;
    } regs_t;

    regs_t r_q, r_d;

    logic              cls_err;
    logic [DATA_W-1:0] cls_rdata;

    wbb_classify #(
        .DATA_W      (DATA_W),
        .ERR_BAD_ADDR(ERR_BAD_ADDR),
        .ERR_BAD_DIR (ERR_BAD_DIR)
    ) u_classify (
        .is_read  (!r_q.write),
        .bad_addr (rsp_bad_addr),
        .bad_dir  (rsp_bad_dir),
        .tgt_rdata(rsp_rdata),
        .raise_err(cls_err),
        .ret_rdata(cls_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.err  = 1'b0;
        r_d.rdat = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (bus_stb) begin
                    r_d.state = ST_BUSY;
                    r_d.write = bus_we;
                    r_d.addr  = bus_adr;
                    r_d.wdata = bus_wdat;
                    r_d.wmask = bus_sel;
                end
            end
            ST_BUSY: begin
                if (rsp_done) begin
                    r_d.state = ST_RESP;
                    r_d.err   = cls_err;
                    r_d.ack   = !cls_err;
                    r_d.rdat  = cls_err ? '0 : cls_rdata;
                end
            end
            ST_RESP: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_stall = (r_q.state != ST_IDLE);
    assign bus_ack   = r_q.ack;
    assign bus_err   = r_q.err;
    assign bus_rdat  = r_q.rdat;
    assign req_valid = (r_q.state == ST_BUSY);
    assign req_write = r_q.write;
    assign req_addr  = r_q.addr;
    assign req_wdata = r_q.wdata;
    assign req_wmask = r_q.wmask;

    // R1: capture does not depend on the cycle input
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_stall && bus_stb && !bus_cyc) |=> req_valid);

    // R2: completion is a single-cycle pulse
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_err) |=> !(bus_ack || bus_err));

    // R2: done while outstanding is answered next cycle
    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_done) |=> (bus_ack || bus_err));

    // R3: stall covers the response cycle
    p_stall_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_err) |-> bus_stall);

    // R4: the issued request is frozen until done
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_done) |=>
            (req_valid && $stable(req_addr) && $stable(req_wdata)
             && $stable(req_write) && $stable(req_wmask)));

    // R5: reported bad address gives error only
    p_bad_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_done && rsp_bad_addr && ERR_BAD_ADDR) |=>
            (bus_err && !bus_ack));

    // R6: reported bad direction gives error only
    p_bad_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_done && rsp_bad_dir && ERR_BAD_DIR) |=>
            (bus_err && !bus_ack));

    // R7: unreported faults complete normally with zero data
    p_quiet_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_done && (rsp_bad_addr || rsp_bad_dir)
         && !(rsp_bad_addr && ERR_BAD_ADDR) && !(rsp_bad_dir && ERR_BAD_DIR))
            |=> (bus_ack && bus_rdat == '0));

    // R8: never both responses
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err));

    // R9: read data is zero outside an acknowledge
    p_rdat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdat == '0));

endmodule

// File: tb/wb_reg_bridge_test.sv
`timescale 1ns/1ps

module wb_reg_bridge_tgt (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_wmask,
    input  logic [3:0]  lat,
    output logic        done,
    output logic [31:0] rdata,
    output logic        bad_addr,
    output logic        bad_dir
);
    logic [31:0] mem [8];
    logic [3:0]  cnt;

    assign done     = req_valid && (cnt == lat);
    assign bad_addr = (req_addr > 8'd9);
    assign bad_dir  = (req_addr == 8'd8 && req_write) || (req_addr == 8'd9 && !req_write);

    always_comb begin
        if (bad_addr || bad_dir)      rdata = 32'hDEAD_BEEF;
        else if (req_addr == 8'd8)    rdata = 32'hA5A5_0008;
        else if (req_addr < 8'd8)     rdata = mem[req_addr[2:0]];
        else                          rdata = 32'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < 8; i++) mem[i] <= '0;
        end else begin
            cnt <= (req_valid && !done) ? cnt + 4'd1 : 4'd0;
            if (done && req_write && req_addr < 8'd8) begin
                for (int b = 0; b < 4; b++) begin
                    if (req_wmask[b]) mem[req_addr[2:0]][8*b +: 8] <= req_wdata[8*b +: 8];
                end
            end
        end
    end
endmodule

module wb_reg_bridge_test;

    typedef struct packed {
        logic        we;
        logic [7:0]  adr;
        logic [31:0] dat;
        logic [3:0]  sel;
        logic [3:0]  lat;
        logic        cyc;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h03, 32'h1122_3344, 4'hF, 4'd0, 1'b1},
        '{1'b0, 8'h03, 32'h0,         4'hF, 4'd1, 1'b0},
        '{1'b1, 8'h03, 32'hAABB_CCDD, 4'h5, 4'd2, 1'b1},
        '{1'b0, 8'h03, 32'h0,         4'hF, 4'd0, 1'b1},
        '{1'b0, 8'h08, 32'h0,         4'hF, 4'd1, 1'b1},
        '{1'b1, 8'h08, 32'h7777_7777, 4'hF, 4'd0, 1'b0},
        '{1'b1, 8'h09, 32'h1234_5678, 4'hF, 4'd3, 1'b1},
        '{1'b0, 8'h09, 32'h0,         4'hF, 4'd1, 1'b1},
        '{1'b0, 8'h40, 32'h0,         4'hF, 4'd2, 1'b0},
        '{1'b1, 8'hFF, 32'h5555_5555, 4'hF, 4'd0, 1'b1},
        '{1'b1, 8'h07, 32'h5A00_0000, 4'h8, 4'd1, 1'b0},
        '{1'b0, 8'h07, 32'h0,         4'hF, 4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_adr = '0;
    logic [31:0] bus_wdat = '0;
    logic [3:0]  bus_sel = '0;
    logic [3:0]  lat = '0;

    logic        stall_a, ack_a, err_a, rv_a, rw_a, done_a, ba_a, bd_a;
    logic [31:0] rdat_a, wd_a, td_a;
    logic [7:0]  ad_a;
    logic [3:0]  wm_a;
    logic        stall_b, ack_b, err_b, rv_b, rw_b, done_b, ba_b, bd_b;
    logic [31:0] rdat_b, wd_b, td_b;
    logic [7:0]  ad_b;
    logic [3:0]  wm_b;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] shadow [8];

    always #2 clk = ~clk;

    wb_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_sel(bus_sel),
        .bus_stall(stall_a), .bus_ack(ack_a), .bus_err(err_a), .bus_rdat(rdat_a),
        .req_valid(rv_a), .req_write(rw_a), .req_addr(ad_a), .req_wdata(wd_a), .req_wmask(wm_a),
        .rsp_done(done_a), .rsp_rdata(td_a), .rsp_bad_addr(ba_a), .rsp_bad_dir(bd_a)
    );
    wb_reg_bridge_tgt tgt_a (
        .clk(clk), .rst_n(rst_n), .req_valid(rv_a), .req_write(rw_a), .req_addr(ad_a),
        .req_wdata(wd_a), .req_wmask(wm_a), .lat(lat), .done(done_a), .rdata(td_a),
        .bad_addr(ba_a), .bad_dir(bd_a)
    );

    wb_reg_bridge #(.ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_sel(bus_sel),
        .bus_stall(stall_b), .bus_ack(ack_b), .bus_err(err_b), .bus_rdat(rdat_b),
        .req_valid(rv_b), .req_write(rw_b), .req_addr(ad_b), .req_wdata(wd_b), .req_wmask(wm_b),
        .rsp_done(done_b), .rsp_rdata(td_b), .rsp_bad_addr(ba_b), .rsp_bad_dir(bd_b)
    );
    wb_reg_bridge_tgt tgt_b (
        .clk(clk), .rst_n(rst_n), .req_valid(rv_b), .req_write(rw_b), .req_addr(ad_b),
        .req_wdata(wd_b), .req_wmask(wm_b), .lat(lat), .done(done_b), .rdata(td_b),
        .bad_addr(ba_b), .bad_dir(bd_b)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic we, input logic [7:0] adr, input logic [31:0] dat,
                       input logic [3:0] sel, input logic [3:0] l, input logic cyc,
                       input bit mutate, output logic [31:0] got);
        bit    bad_a, bad_d, good;
        logic  e_err;
        logic [31:0] e_rdat;
        string tag;
        int    k;
        bad_a = (adr > 8'd9);
        bad_d = (adr == 8'd8 && we) || (adr == 8'd9 && !we);
        good  = !bad_a && !bad_d;
        e_err = !good;
        if (!we && good) e_rdat = (adr == 8'd8) ? 32'hA5A5_0008 : shadow[adr[2:0]];
        else             e_rdat = 32'h0;
        tag = bad_a ? "R5" : (bad_d ? "R6" : "R1");

        bus_we = we; bus_adr = adr; bus_wdat = dat; bus_sel = sel;
        lat = l; bus_cyc = cyc; bus_stb = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                check(stall_a == 1'b1, "R3 stall after capture", {31'b0, stall_a}, 32'h1);
                if (mutate) begin
                    bus_adr  = bus_adr ^ 8'h01;
                    bus_wdat = ~bus_wdat;
                    bus_we   = ~we;
                    bus_sel  = 4'hF;
                end
            end
        end while (!(ack_a || err_a) && k < 40);

        check(k == int'(l) + 2, "R2 response latency", k, int'(l) + 2);
        check(err_a == e_err && ack_a == !e_err, tag, {30'b0, ack_a, err_a}, {30'b0, !e_err, e_err});
        check(!(ack_a && err_a) && !(ack_b && err_b), "R8 exclusive", {30'b0, ack_a, err_a},
              {30'b0, !e_err, e_err});
        check(rdat_a == e_rdat, "R9 read data", rdat_a, e_rdat);
        check(ack_b == 1'b1 && err_b == 1'b0 && rdat_b == e_rdat, "R7 options off",
              rdat_b, e_rdat);
        got = rdat_a;

        bus_stb = 1'b0;
        @(negedge clk);
        check(!ack_a && !err_a && !stall_a, "R2 R3 pulse ends, idle",
              {29'b0, ack_a, err_a, stall_a}, 32'h0);

        if (we && adr < 8'd8) begin
            for (int b = 0; b < 4; b++)
                if (sel[b]) shadow[adr[2:0]][8*b +: 8] = dat[8*b +: 8];
        end
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 8; i++) shadow[i] = '0;

        repeat (3) @(negedge clk);
        check(!ack_a && !err_a && !stall_a && !rv_a, "R10 reset state",
              {28'b0, ack_a, err_a, stall_a, rv_a}, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            run(VECS[v].we, VECS[v].adr, VECS[v].dat, VECS[v].sel, VECS[v].lat,
                VECS[v].cyc, 1'b0, got);
        end

        // R11: byte-masked writes merged as the mask selects
        run(1'b0, 8'h03, 32'h0, 4'hF, 4'd0, 1'b0, 1'b0, got);
        check(got == 32'h11BB_33DD, "R11 mask bytes 0,2", got, 32'h11BB_33DD);
        run(1'b0, 8'h07, 32'h0, 4'hF, 4'd2, 1'b1, 1'b0, got);
        check(got == 32'h5A00_0000, "R11 mask byte 3", got, 32'h5A00_0000);

        // R4: bus changes after capture must not alter the access
        run(1'b1, 8'h05, 32'h0000_F0F0, 4'hF, 4'd3, 1'b1, 1'b1, got);
        run(1'b0, 8'h05, 32'h0, 4'hF, 4'd0, 1'b1, 1'b0, got);
        check(got == 32'h0000_F0F0, "R4 captured address written", got, 32'h0000_F0F0);
        run(1'b0, 8'h04, 32'h0, 4'hF, 4'd1, 1'b1, 1'b0, got);
        check(got == 32'h0, "R4 mutated address untouched", got, 32'h0);

        // R10: reset in the middle of an outstanding request
        bus_we = 1'b1; bus_adr = 8'h02; bus_wdat = 32'hCAFE_F00D; bus_sel = 4'hF;
        lat = 4'd6; bus_cyc = 1'b1; bus_stb = 1'b1;
        repeat (2) @(negedge clk);
        check(rv_a == 1'b1, "R10 request outstanding before reset", {31'b0, rv_a}, 32'h1);
        rst_n = 1'b0; bus_stb = 1'b0;
        @(negedge clk);
        check(!ack_a && !err_a && !stall_a && !rv_a, "R10 outputs cleared by reset",
              {28'b0, ack_a, err_a, stall_a, rv_a}, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        rst_n = 1'b1;
        run(1'b0, 8'h02, 32'h0, 4'hF, 4'd0, 1'b0, 1'b0, got);
        check(got == 32'h0, "R10 first access after release", got, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule